// File: doc/BRIEF.md
# SDRAM Command Timing Sequencer

This block sits between a memory request stream and the pins of a single-bank SDR SDRAM. It takes one read or write request at a time: a row address, a column address, a direction and a burst-length code. It turns that request into a cycle-exact stream of row-open, column and row-close commands. The commands appear on three active-low strobes (row strobe, column strobe, write enable) and one multiplexed address bus. The sequencer keeps the most recently opened row open. A request to that row gets a column command only. A request to any other row first closes the open row, then opens the new row, and only then issues its column command.

Five programmable spacing rules govern the command stream: row-open to column, row-close to row-open, row-open to row-close, end of the column burst to row-close, and the minimum gap between any two commands. The values are captured while reset is held and are ignored after that. For reads the block raises a data-valid flag in the cycles where the memory drives read words. It also marks the column commands that were served from an already open row.

Requests use a valid/ready handshake. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. While `req_ready` is low the source must hold the request stable. Ready is high when nothing is pending. It is also high in the cycle where the pending request's column command is being scheduled, so hits can be accepted and issued back to back.

Top module: `sdram_cmd_seq`

## Requirements
- R1: Commands are encoded on {sd_ras_n, sd_cas_n, sd_we_n} as idle 111, row-open 011, read column 101, write column 100 and row-close 010. Every cycle without a command drives idle, and no other encoding ever appears. After reset the outputs are idle.
- R2: For a request that finds no open row, a row-open command carries the request row on sd_addr. The column command follows exactly tRCD cycles later, provided the command gap allows it, and carries the column zero-extended on sd_addr.
- R3: A read column command issued in cycle c raises rd_valid from cycle c+CL for as many cycles as the burst has words: code 0 gives 2 words, code 1 gives 4, and codes 2 and 3 give 8. rd_valid is low after reset.
- R4: A request to the open row produces only a column command, with no row-open and no row-close. row_hit is high in exactly that column cycle. row_hit is low for columns that needed a row-open.
- R5: Any two commands are at least one cycle apart when cfg_rate2 is 0, and at least two cycles apart when it is 1. Back-to-back hits reach exactly that spacing.
- R6: A row-close is issued only for a request to a different row. It waits until at least tRAS cycles after the row-open and at least as many cycles after the last column command as that burst had words. It is issued at the later of the two.
- R7: A row-open that follows a row-close comes exactly tRP cycles after it, provided the command gap allows it.
- R8: req_ready is high after reset. It is low while a request waits for its row-close or row-open, and no request is taken while it is low.
- R9: The timing inputs are sampled only while rst_n is low. Changing them afterwards has no effect on command spacing. A timing value of 0 acts as 1, and CL is clamped to 1..CL_MAX.
- R10: A write produces a write column command (sd_we_n low) and never raises rd_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all strobes change after its rising edge |
| rst_n | input | 1 | Active-low reset; timing inputs are captured while low |
| cfg_trcd | input | CNT_W | Row-open to column spacing, cycles |
| cfg_cas_lat | input | CNT_W | Read latency CL, cycles |
| cfg_trp | input | CNT_W | Row-close to row-open spacing, cycles |
| cfg_tras | input | CNT_W | Row-open to row-close minimum, cycles |
| cfg_rate2 | input | 1 | 1 selects a two-cycle minimum command gap |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_row | input | ROW_W | Row address |
| req_col | input | COL_W | Column address |
| req_burst | input | 2 | Burst code: 0=2, 1=4, 2/3=8 words |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | ADDR_W | Multiplexed row/column address |
| rd_valid | output | 1 | Read data word present on the memory data bus |
| row_hit | output | 1 | Current column command skipped row-open |

## Verification
Two things can fall in the same cycle: acceptance of a new request and scheduling of the pending request's column command. The bench provokes this by offering a second request to the open row while the first is still pending. It then judges the overlap by the spacing between the two column commands, which must equal the command gap (one cycle, and two with cfg_rate2 set). The row-close rule is exercised once with tRAS as the limiting term and once with an 8-word burst as the limiting term. The exact cycle of the row-close confirms that the later of the two wins.

// File: rtl/sdram_seq_pkg.sv
`timescale 1ns/1ps
package sdram_seq_pkg;

  // Strobe encodings {ras_n, cas_n, we_n}
  typedef enum logic [2:0] {
    CMD_IDLE  = 3'b111,
    CMD_OPEN  = 3'b011,
    CMD_READ  = 3'b101,
    CMD_WRITE = 3'b100,
    CMD_CLOSE = 3'b010
  } cmd_t;

  // Spacing timers
  localparam int unsigned N_TIMERS  = 5;
  localparam int unsigned TMR_RCD   = 0;
  localparam int unsigned TMR_RAS   = 1;
  localparam int unsigned TMR_RP    = 2;
  localparam int unsigned TMR_BURST = 3;
  localparam int unsigned TMR_GAP   = 4;

  function automatic logic [3:0] burst_words(input logic [1:0] code);
    case (code)
      2'd0:    burst_words = 4'd2;
      2'd1:    burst_words = 4'd4;
      default: burst_words = 4'd8;
    endcase
  endfunction

endpackage

// File: rtl/sdram_gap_timer.sv
`timescale 1ns/1ps
module sdram_gap_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] span,
  output logic         expired
);

  logic [W-1:0] cnt_q;

  // A command in cycle c loaded with span S frees the next one in cycle c+S.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= (span == '0) ? '0 : span - 1'b1;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/sdram_rd_window.sv
`timescale 1ns/1ps
module sdram_rd_window #(
  parameter int CL_MAX = 8,
  parameter int CNT_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue,
  input  logic [3:0]       words,
  input  logic [CNT_W-1:0] cas_lat,
  output logic             data_valid
);

  logic [CL_MAX-1:0] stg_v;
  logic [3:0]        stg_w [CL_MAX];
  logic [3:0]        remain_q;
  int                tap;

  always_comb begin
    if (cas_lat == '0)               tap = 0;
    else if (int'(cas_lat) > CL_MAX) tap = CL_MAX - 1;
    else                             tap = int'(cas_lat) - 1;
  end

  // Delay line: stage k is visible k cycles after the read column cycle.
  for (genvar k = 0; k < CL_MAX; k++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stg_v[k] <= 1'b0;
        stg_w[k] <= '0;
      end else if (k == 0) begin
        stg_v[k] <= issue;
        stg_w[k] <= words;
      end else begin
        stg_v[k] <= stg_v[k-1];
        stg_w[k] <= stg_w[k-1];
      end
    end
  end

  // A newer read arriving at the tap cuts an older burst short.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               remain_q <= '0;
    else if (stg_v[tap])      remain_q <= stg_w[tap];
    else if (remain_q != '0)  remain_q <= remain_q - 1'b1;
  end

  assign data_valid = (remain_q != '0);

  AST_RD_ONLY_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_valid) |-> $past(stg_v[tap]));  // R3

endmodule

// File: rtl/sdram_cmd_seq.sv
`timescale 1ns/1ps
module sdram_cmd_seq
  import sdram_seq_pkg::*;
#(
  parameter int ROW_W  = 12,
  parameter int COL_W  = 8,
  parameter int CNT_W  = 4,
  parameter int CL_MAX = 8,
  parameter int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cfg_trcd,
  input  logic [CNT_W-1:0]  cfg_cas_lat,
  input  logic [CNT_W-1:0]  cfg_trp,
  input  logic [CNT_W-1:0]  cfg_tras,
  input  logic              cfg_rate2,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic [1:0]        req_burst,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [ADDR_W-1:0] sd_addr,
  output logic              rd_valid,
  output logic              row_hit
);

  localparam logic [CNT_W-1:0] SAT = {CNT_W{1'b1}};

  // Timing set, captured while reset is held
  logic [CNT_W-1:0] trcd_q, cl_q, trp_q, tras_q;
  logic             rate2_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trcd_q  <= cfg_trcd;
      cl_q    <= cfg_cas_lat;
      trp_q   <= cfg_trp;
      tras_q  <= cfg_tras;
      rate2_q <= cfg_rate2;
    end
  end

  // Pending request and open-row state
  logic             pend_q, pend_wr_q, pend_hit_q;
  logic [ROW_W-1:0] pend_row_q;
  logic [COL_W-1:0] pend_col_q;
  logic [1:0]       pend_bl_q;
  logic             open_q;
  logic [ROW_W-1:0] open_row_q;

  logic row_match, fire_open, fire_close, fire_col, accept, any_cmd;
  logic [N_TIMERS-1:0] tmr_done, tmr_load;
  logic [CNT_W-1:0]    tmr_span [N_TIMERS];
  logic [3:0]          pend_words;

  assign pend_words = burst_words(pend_bl_q);
  assign row_match  = open_q && (open_row_q == pend_row_q);

  assign fire_col   = pend_q && row_match && tmr_done[TMR_RCD] && tmr_done[TMR_GAP];
  assign fire_close = pend_q && open_q && !row_match && tmr_done[TMR_RAS]
                      && tmr_done[TMR_BURST] && tmr_done[TMR_GAP];
  assign fire_open  = pend_q && !open_q && tmr_done[TMR_RP] && tmr_done[TMR_GAP];
  assign any_cmd    = fire_col || fire_close || fire_open;

  assign req_ready  = !pend_q || fire_col;
  assign accept     = req_valid && req_ready;

  // Timer bank: one countdown per spacing rule
  always_comb begin
    tmr_load[TMR_RCD]   = fire_open;
    tmr_span[TMR_RCD]   = trcd_q;
    tmr_load[TMR_RAS]   = fire_open;
    tmr_span[TMR_RAS]   = tras_q;
    tmr_load[TMR_RP]    = fire_close;
    tmr_span[TMR_RP]    = trp_q;
    tmr_load[TMR_BURST] = fire_col;
    tmr_span[TMR_BURST] = CNT_W'(pend_words);
    tmr_load[TMR_GAP]   = any_cmd;
    tmr_span[TMR_GAP]   = rate2_q ? CNT_W'(2) : CNT_W'(1);
  end

  for (genvar t = 0; t < N_TIMERS; t++) begin : g_tmr
    sdram_gap_timer #(.W(CNT_W)) i_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (tmr_load[t]),
      .span    (tmr_span[t]),
      .expired (tmr_done[t])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q     <= 1'b0;
      pend_wr_q  <= 1'b0;
      pend_hit_q <= 1'b0;
      pend_row_q <= '0;
      pend_col_q <= '0;
      pend_bl_q  <= '0;
    end else if (accept) begin
      pend_q     <= 1'b1;
      pend_wr_q  <= req_write;
      pend_hit_q <= open_q && (open_row_q == req_row);
      pend_row_q <= req_row;
      pend_col_q <= req_col;
      pend_bl_q  <= req_burst;
    end else if (fire_col) begin
      pend_q     <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q     <= 1'b0;
      open_row_q <= '0;
    end else if (fire_open) begin
      open_q     <= 1'b1;
      open_row_q <= pend_row_q;
    end else if (fire_close) begin
      open_q     <= 1'b0;
    end
  end

  // Registered command stream
  cmd_t              cmd_d, cmd_q;
  logic [ADDR_W-1:0] addr_d, addr_q, row_ext, col_ext;
  logic              hit_q;

  always_comb begin
    row_ext = '0;
    row_ext[ROW_W-1:0] = pend_row_q;
    col_ext = '0;
    col_ext[COL_W-1:0] = pend_col_q;
    cmd_d  = CMD_IDLE;
    addr_d = '0;
    if (fire_open) begin
      cmd_d  = CMD_OPEN;
      addr_d = row_ext;
    end else if (fire_close) begin
      cmd_d  = CMD_CLOSE;
    end else if (fire_col) begin
      cmd_d  = pend_wr_q ? CMD_WRITE : CMD_READ;
      addr_d = col_ext;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= CMD_IDLE;
      addr_q <= '0;
      hit_q  <= 1'b0;
    end else begin
      cmd_q  <= cmd_d;
      addr_q <= addr_d;
      hit_q  <= fire_col && pend_hit_q;
    end
  end

  assign {sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;
  assign sd_addr = addr_q;
  assign row_hit = hit_q;

  sdram_rd_window #(.CL_MAX(CL_MAX), .CNT_W(CNT_W)) i_rdwin (
    .clk        (clk),
    .rst_n      (rst_n),
    .issue      (fire_col && !pend_wr_q),
    .words      (pend_words),
    .cas_lat    (cl_q),
    .data_valid (rd_valid)
  );

  // Checker: cycles elapsed since each command kind, seen at the strobes
  logic [CNT_W-1:0] since_open, since_close, since_col, since_any;
  logic [3:0]       chk_words;
  logic             is_col;

  assign is_col = (cmd_q == CMD_READ) || (cmd_q == CMD_WRITE);

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == SAT) ? v : v + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_open  <= SAT;
      since_close <= SAT;
      since_col   <= SAT;
      since_any   <= SAT;
      chk_words   <= '0;
    end else begin
      since_open  <= (cmd_q == CMD_OPEN)  ? CNT_W'(1) : sat_inc(since_open);
      since_close <= (cmd_q == CMD_CLOSE) ? CNT_W'(1) : sat_inc(since_close);
      since_col   <= is_col               ? CNT_W'(1) : sat_inc(since_col);
      since_any   <= (cmd_q != CMD_IDLE)  ? CNT_W'(1) : sat_inc(since_any);
      if (fire_col) chk_words <= pend_words;
    end
  end

  AST_CMD_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_q inside {CMD_IDLE, CMD_OPEN, CMD_READ, CMD_WRITE, CMD_CLOSE});  // R1
  AST_OPEN_TO_COL: assert property (@(posedge clk) disable iff (!rst_n)
    is_col |-> since_open >= trcd_q);  // R2
  AST_HIT_IS_COL: assert property (@(posedge clk) disable iff (!rst_n)
    row_hit |-> is_col);  // R4
  AST_CMD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q != CMD_IDLE) |-> since_any >= (rate2_q ? CNT_W'(2) : CNT_W'(1)));  // R5
  AST_CLOSE_AFTER_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_CLOSE) |-> since_open >= tras_q);  // R6
  AST_CLOSE_AFTER_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_CLOSE) |-> since_col >= CNT_W'(chk_words));  // R6
  AST_OPEN_AFTER_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_OPEN) |-> since_close >= trp_q);  // R7
  AST_HOLD_WHEN_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !req_ready) |=> (pend_q && $stable(pend_row_q) && $stable(pend_col_q)));  // R8

endmodule

// File: tb/test_sdram_cmd_seq.sv
`timescale 1ns/1ps
module test_sdram_cmd_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  cfg_trcd, cfg_cas_lat, cfg_trp, cfg_tras;
  logic        cfg_rate2;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic        req_ready;
  logic [11:0] req_row = '0;
  logic [7:0]  req_col = '0;
  logic [1:0]  req_burst = '0;
  logic        sd_ras_n, sd_cas_n, sd_we_n, rd_valid, row_hit;
  logic [11:0] sd_addr;

  sdram_cmd_seq i_sdram_cmd_seq (
    .clk(clk), .rst_n(rst_n),
    .cfg_trcd(cfg_trcd), .cfg_cas_lat(cfg_cas_lat), .cfg_trp(cfg_trp),
    .cfg_tras(cfg_tras), .cfg_rate2(cfg_rate2),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_row(req_row), .req_col(req_col), .req_burst(req_burst),
    .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
    .sd_addr(sd_addr), .rd_valid(rd_valid), .row_hit(row_hit)
  );

  always #2 clk = ~clk;  // 250 MHz

  int checks = 0, fails = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Monitor state, updated at falling edges
  int n_act = 0, n_pre = 0, n_col = 0, n_bad = 0;
  int last_act = -100, last_pre = -100, last_col = -100;
  int act_minus_pre = 0, pre_minus_act = 0, pre_minus_col = 0, col_minus_act = 0, col_gap = 0;
  int act_addr = 0, col_addr = 0, col_we = 1, col_hit = 0;
  int rd_first = -1, rd_cnt = 0;
  logic rd_prev = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      case ({sd_ras_n, sd_cas_n, sd_we_n})
        3'b111: ;
        3'b011: begin
          act_minus_pre = cyc - last_pre; last_act = cyc; act_addr = int'(sd_addr); n_act++;
        end
        3'b010: begin
          pre_minus_act = cyc - last_act; pre_minus_col = cyc - last_col; last_pre = cyc; n_pre++;
        end
        3'b101, 3'b100: begin
          col_minus_act = cyc - last_act; col_gap = cyc - last_col; last_col = cyc;
          col_addr = int'(sd_addr); col_we = int'(sd_we_n); col_hit = int'(row_hit); n_col++;
        end
        default: n_bad++;
      endcase
      if (row_hit && !({sd_ras_n, sd_cas_n} == 2'b10)) n_bad++;
      if (rd_valid) begin
        if (!rd_prev) rd_first = cyc;
        rd_cnt++;
      end
      rd_prev = rd_valid;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int words_of(input int code);
    return (code == 0) ? 2 : (code == 1) ? 4 : 8;
  endfunction

  task automatic do_reset(input int trcd, input int cl, input int trp, input int tras, input bit r2);
    rst_n = 1'b0;
    req_valid = 1'b0;
    cfg_trcd = 4'(trcd); cfg_cas_lat = 4'(cl); cfg_trp = 4'(trp); cfg_tras = 4'(tras);
    cfg_rate2 = r2;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    n_act = 0; n_pre = 0; n_col = 0;
    // Disturb the timing inputs after release (R9)
    cfg_trcd = 4'd9; cfg_cas_lat = 4'd6; cfg_trp = 4'd7; cfg_tras = 4'd1; cfg_rate2 = ~r2;
  endtask

  task automatic send(input bit wr, input int row, input int col, input int bl);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr;
    req_row = 12'(row); req_col = 8'(col); req_burst = 2'(bl);
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  task automatic wait_cols(input int target);
    int guard = 0;
    while (n_col < target && guard < 300) begin
      @(posedge clk);
      guard++;
    end
  endtask

  // Vector: [23] write, [22:21] burst code, [20] expected hit, [19:8] row, [7:0] col
  localparam logic [23:0] VEC [8] = '{
    {1'b0, 2'd0, 1'b0, 12'h123, 8'h10},
    {1'b0, 2'd1, 1'b1, 12'h123, 8'h24},
    {1'b1, 2'd2, 1'b1, 12'h123, 8'h31},
    {1'b0, 2'd2, 1'b0, 12'h456, 8'h05},
    {1'b1, 2'd3, 1'b1, 12'h456, 8'hFF},
    {1'b0, 2'd1, 1'b0, 12'h000, 8'h00},
    {1'b0, 2'd0, 1'b0, 12'hFFF, 8'h80},
    {1'b0, 2'd3, 1'b1, 12'hFFF, 8'h7F}
  };

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    // Main timing set: tRCD=3 CL=2 tRP=2 tRAS=8, one-cycle gap
    do_reset(3, 2, 2, 8, 1'b0);
    @(negedge clk);
    chk("R1", "idle strobes after reset", int'({sd_ras_n, sd_cas_n, sd_we_n}), 7);
    chk("R8", "ready after reset", int'(req_ready), 1);
    chk("R3", "rd_valid after reset", int'(rd_valid), 0);
    chk("R4", "row_hit after reset", int'(row_hit), 0);

    for (int i = 0; i < 8; i++) begin
      automatic bit wr  = VEC[i][23];
      automatic int bl  = int'(VEC[i][22:21]);
      automatic bit hit = VEC[i][20];
      automatic int row = int'(VEC[i][19:8]);
      automatic int col = int'(VEC[i][7:0]);
      automatic int a0 = n_act, p0 = n_pre, c0 = n_col;
      rd_cnt = 0; rd_first = -1;
      send(wr, row, col, bl);
      if (!hit) begin
        @(negedge clk);
        chk("R8", "ready low while row not open", int'(req_ready), 0);
      end
      wait_cols(c0 + 1);
      chk("R2", "column address", col_addr, col);
      chk("R10", "write enable on column", col_we, wr ? 0 : 1);
      chk("R4", "row_hit flag", col_hit, int'(hit));
      if (hit) begin
        chk("R4", "no row-open on hit", n_act - a0, 0);
        chk("R4", "no row-close on hit", n_pre - p0, 0);
      end else begin
        chk("R2", "one row-open on miss", n_act - a0, 1);
        chk("R2", "row address on row-open", act_addr, row);
        chk("R2", "row-open to column", col_minus_act, 3);
        if (i > 0) begin
          chk("R6", "row-close before new row", n_pre - p0, 1);
          chk("R7", "row-close to row-open", act_minus_pre, 2);
        end
      end
      repeat (14) @(negedge clk);
      if (wr) begin
        chk("R10", "no read data for write", rd_cnt, 0);
      end else begin
        chk("R3", "first read word cycle", rd_first, last_col + 2);
        chk("R3", "read words", rd_cnt, words_of(bl));
      end
    end

    // tRAS dominates the row-close: open at a, column at a+3, close at a+8
    begin
      automatic int c0 = n_col;
      send(1'b0, 12'h010, 8'h01, 0);
      send(1'b0, 12'h020, 8'h02, 0);
      wait_cols(c0 + 2);
      chk("R6", "close waits tRAS after open", pre_minus_act, 8);
      chk("R6", "close after column (tRAS bound)", pre_minus_col, 5);
      chk("R2", "row-open to column for new row", col_minus_act, 3);
    end
    repeat (14) @(negedge clk);

    // Back-to-back hits with one-cycle gap
    begin
      automatic int c0 = n_col, a0 = n_act;
      send(1'b1, 12'h020, 8'h10, 0);
      send(1'b1, 12'h020, 8'h11, 0);
      wait_cols(c0 + 2);
      chk("R5", "hit column spacing, gap 1", col_gap, 1);
      chk("R4", "row_hit on second hit", col_hit, 1);
      chk("R4", "no row-open for hits", n_act - a0, 0);
    end
    repeat (14) @(negedge clk);
    chk("R1", "illegal strobe patterns", n_bad, 0);

    // Burst end dominates the row-close: tRAS=2, 8-word burst
    do_reset(3, 2, 2, 2, 1'b0);
    send(1'b0, 12'h100, 8'h00, 2);
    send(1'b0, 12'h200, 8'h00, 0);
    wait_cols(2);
    chk("R6", "close waits for 8-word burst", pre_minus_col, 8);
    chk("R6", "close to earlier open", pre_minus_act, 11);
    chk("R9", "row-open to column ignores late config", col_minus_act, 3);
    repeat (14) @(negedge clk);

    // Two-cycle gap: one miss then two held hits
    do_reset(3, 2, 2, 8, 1'b1);
    send(1'b0, 12'h055, 8'h00, 0);
    send(1'b0, 12'h055, 8'h01, 0);
    send(1'b0, 12'h055, 8'h02, 0);
    wait_cols(3);
    chk("R5", "hit column spacing, gap 2", col_gap, 2);
    chk("R4", "one row-open for miss plus hits", n_act, 1);
    repeat (14) @(negedge clk);
    chk("R1", "illegal strobe patterns at end", n_bad, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule